// File: doc/BRIEF.md
# Saturating Event Counter Monitor

This block counts cache events for performance analysis. Two identical 32-bit counters each pick one event line out of a set of single-cycle pulses coming from a cache controller, selected by a per-counter configuration register. A global control register gates both counters at once. Software programs the source codes, clears or presets the counts, and reads them back through a plain 32-bit register port with a combinational read path.

Counts never wrap: a counter that reaches all-ones holds there until software writes a new value, so a reader can tell that the count was clipped. The per-counter registers are laid out in descending pairs: the register for counter 1 sits at the lower word address and the one for counter 0 follows it. Source codes 0xA to 0xF belong to an extended event set that a parameter turns on.

Register map (word addresses): 0x00 control (bit 0 = global enable); 0x04 counter 1 config, 0x08 counter 0 config; 0x0C counter 1 value, 0x10 counter 0 value. Config layout: bits [5:2] source code, bits [1:0] interrupt-control field (stored only).

Top module: `evmon_top`

## Requirements
- R1: After reset the control register, both config registers and both value registers read 0 (global enable clear, source code 0 = disabled).
- R2: While control bit 0 is clear, no counter advances whatever the event inputs do.
- R3: A counter with source code c (1 to 9, or 0xA to 0xF when extended) advances by one on each clock edge at which event input bit c-1 is high and the global enable is set, and ignores all other event bits.
- R4: Source code 0 stops its counter from advancing.
- R5: A counter holding 0xFFFFFFFF stays at 0xFFFFFFFF on further events; it does not wrap.
- R6: A write to a value register loads the written data; a write in the same cycle as a counted event takes priority, so the event is lost.
- R7: Counter 1's config is at 0x04 and counter 0's at 0x08; counter 1's value is at 0x0C and counter 0's at 0x10.
- R8: With EXT_EVENTS = 0, source codes 0xA to 0xF count nothing; with EXT_EVENTS = 1 they count event bits 9 to 14.
- R9: A config register keeps only bits [5:0] (source at [5:2], interrupt field at [1:0]) and reads other bits as 0; reads have no side effect; unmapped addresses read 0.
- R10: A counter advances by at most one per cycle even when many event bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 15 | Event pulses; bit c-1 belongs to source code c |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |

## Verification
The hardest situations to reach from the ports are saturation and the write-versus-event collision. Saturation would take four billion events, so the bench presets a value register close to all-ones through the normal write path and then pulses the selected event past the limit. The collision is forced by raising the selected event line and the value write strobe in the same cycle, then reading the value back to confirm the written data wins. The base-only variant is covered by a second instance sharing the same bus and events.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int DATA_W  = 32;
  localparam int SRC_W   = 4;
  localparam int IRQ_W   = 2;
  localparam int NUM_EVT = (1 << SRC_W) - 1;
  localparam logic [SRC_W-1:0] SRC_OFF   = '0;
  localparam logic [SRC_W-1:0] FIRST_EXT = 4'hA;
  localparam int CTRL_OFF = 0;
  localparam int CFG_BASE = 4;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [IRQ_W-1:0] irq;
  } cnt_cfg_t;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter
  import evmon_pkg::*;
#(
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [SRC_W-1:0]    src_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   cnt_o
);
  logic [NUM_EVT:0] evt_pad;
  logic             src_ok, hit, at_max;
  logic [DATA_W-1:0] cnt_q;

  // code 0 lands on the padded zero bit
  assign evt_pad = {evt_i, 1'b0};
  assign src_ok  = EXT_EVENTS || (src_i < FIRST_EXT);
  assign hit     = en_i && src_ok && evt_pad[src_i];
  assign at_max  = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (wr_i)              cnt_q <= wdata_i;
    else if (hit && !at_max)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !wr_i) |=> cnt_q == '1);
  assert_one_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(cnt_q));
  assert_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_OFF && !wr_i) |=> $stable(cnt_q));
  assert_wr_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/evmon_regs.sv
module evmon_regs
  import evmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int ADDR_W  = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             en_o,
  output logic [NUM_CNT-1:0][SRC_W-1:0]    src_o,
  output logic [NUM_CNT-1:0]               cnt_we_o
);
  localparam int VAL_BASE = CFG_BASE + 4 * NUM_CNT;
  localparam int CFG_W    = SRC_W + IRQ_W;

  // descending layout: highest index at lowest address
  function automatic logic [ADDR_W-1:0] cfg_addr(int k);
    return ADDR_W'(CFG_BASE + 4 * (NUM_CNT - 1 - k));
  endfunction
  function automatic logic [ADDR_W-1:0] val_addr(int k);
    return ADDR_W'(VAL_BASE + 4 * (NUM_CNT - 1 - k));
  endfunction

  logic     en_q;
  cnt_cfg_t cfg_q [NUM_CNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        en_q <= 1'b0;
    else if (we_i && addr_i == ADDR_W'(CTRL_OFF))       en_q <= wdata_i[0];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_q[k] <= '{src: SRC_OFF, irq: '0};
      else if (we_i && addr_i == cfg_addr(k))   cfg_q[k] <= cnt_cfg_t'(wdata_i[CFG_W-1:0]);
    end
    assign src_o[k]    = cfg_q[k].src;
    assign cnt_we_o[k] = we_i && addr_i == val_addr(k);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFF)) rdata_o[0] = en_q;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (addr_i == cfg_addr(k)) rdata_o[CFG_W-1:0] = cfg_q[k];
      if (addr_i == val_addr(k)) rdata_o = cnt_i[k];
    end
  end

  assign en_o = en_q;

  assert_ctrl_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(CTRL_OFF)) |=> en_o == $past(wdata_i[0]));
  assert_val_we_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cnt_we_o));
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int NUM_CNT    = 2,
  parameter int ADDR_W     = 8,
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o
);
  logic                           en;
  logic [NUM_CNT-1:0][SRC_W-1:0]  src;
  logic [NUM_CNT-1:0]             cnt_we;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt;

  evmon_regs #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt), .rdata_o(reg_rdata_o),
    .en_o(en), .src_o(src), .cnt_we_o(cnt_we)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    evmon_counter #(.EXT_EVENTS(EXT_EVENTS)) u_cnt (
      .clk_i, .rst_ni,
      .en_i(en), .evt_i, .src_i(src[k]),
      .wr_i(cnt_we[k]), .wdata_i(reg_wdata_i), .cnt_o(cnt[k])
    );
  end

  // base-only variant: extended codes never count
  if (!EXT_EVENTS) begin : g_base_chk
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_k
      assert_ext_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src[k] >= FIRST_EXT && !cnt_we[k]) |=> $stable(cnt[k]));
    end
  end
endmodule

// File: tb/tb_evmon_top.sv
module tb_evmon_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] evt = '0;
  logic        we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_b;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_CFG1 = 8'h04, A_CFG0 = 8'h08,
                         A_VAL1 = 8'h0C, A_VAL0 = 8'h10;

  always #5 clk = ~clk;

  evmon_top dut (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));
  evmon_top #(.EXT_EVENTS(1'b0)) dut_base (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic [31:0] db);
    @(negedge clk); addr = a; #1; d = rdata; db = rdata_b;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d, db;
    rd(a, d, db);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic [14:0] m, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = m;
    end
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 cfg1", A_CFG1, 0);
    rd_chk("R1 cfg0", A_CFG0, 0);
    rd_chk("R1 val1", A_VAL1, 0);
    rd_chk("R1 val0", A_VAL0, 0);
  endtask

  task automatic t_layout;
    wr(A_CFG1, 32'hFFFF_FFCE);
    rd_chk("R9 cfg keeps [5:0]", A_CFG1, 32'h0000_000E);
    rd_chk("R7 cfg0 untouched", A_CFG0, 0);
    wr(A_VAL1, 32'h1234);
    rd_chk("R7 val1 at 0x0C", A_VAL1, 32'h1234);
    rd_chk("R9 read no side effect", A_VAL1, 32'h1234);
    rd_chk("R7 val0 untouched", A_VAL0, 0);
    rd_chk("R9 unmapped 0x14", 8'h14, 0);
    rd_chk("R9 unaligned 0x02", 8'h02, 0);
    wr(A_CFG1, 0);
    wr(A_VAL1, 0);
  endtask

  task automatic t_select;
    wr(A_CFG0, 2 << 2);
    wr(A_CFG1, 5 << 2);
    wr(A_CTRL, 1);
    pulse(15'h0002, 3);
    pulse(15'h0010, 2);
    pulse(15'h0001, 4);
    rd_chk("R3 cnt0 code2", A_VAL0, 3);
    rd_chk("R3 cnt1 code5", A_VAL1, 2);
    pulse(15'h7FFF, 1);
    rd_chk("R10 cnt0 all high", A_VAL0, 4);
    rd_chk("R10 cnt1 all high", A_VAL1, 3);
  endtask

  task automatic t_enable;
    wr(A_CTRL, 0);
    pulse(15'h7FFF, 5);
    rd_chk("R2 cnt0 gated", A_VAL0, 4);
    rd_chk("R2 cnt1 gated", A_VAL1, 3);
    wr(A_CTRL, 1);
  endtask

  task automatic t_off;
    wr(A_CFG0, 0);
    pulse(15'h7FFF, 3);
    rd_chk("R4 cnt0 disabled", A_VAL0, 4);
    rd_chk("R4 cnt1 still counts", A_VAL1, 6);
  endtask

  task automatic t_sat;
    wr(A_CFG0, 1 << 2);
    wr(A_VAL0, 32'hFFFF_FFFD);
    pulse(15'h0001, 5);
    rd_chk("R5 saturates", A_VAL0, 32'hFFFF_FFFF);
    wr(A_VAL0, 0);
    rd_chk("R6 restart at zero", A_VAL0, 0);
  endtask

  task automatic t_prio;
    @(negedge clk); evt = 15'h0001; we = 1; addr = A_VAL0; wdata = 32'h55;
    @(negedge clk); evt = '0; we = 0;
    rd_chk("R6 write beats event", A_VAL0, 32'h55);
  endtask

  task automatic t_ext;
    logic [31:0] d, db;
    wr(A_CFG0, 32'hA << 2);
    wr(A_VAL0, 0);
    pulse(15'h0200, 3);
    rd(A_VAL0, d, db);
    chk("R8 ext code counts", d, 3);
    chk("R8 base variant ignores 0xA", db, 0);
    wr(A_CFG0, 9 << 2);
    pulse(15'h0100, 2);
    rd(A_VAL0, d, db);
    chk("R8 base variant code 9", db, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_layout;
    t_select;
    t_enable;
    t_off;
    t_sat;
    t_prio;
    t_ext;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule